// File: doc/BRIEF.md
# SPI Master Controller with Register Port

This block is a serial peripheral interface master that a processor drives through a small register port. Software places the block in its configuration mode, programs clock polarity and phase, the word length (8 or 16 bits), a clock divider and a receive threshold, then switches to the active mode. Words written to the data port queue in a four-entry transmit FIFO. While active, the shift engine drains that FIFO one word at a time, driving the serial clock and output line and capturing one input word for every word it sends. Captured words land in a four-entry receive FIFO that software empties by reading the same data port.

A level interrupt tells software that enough words have arrived, so a driver can queue a burst of up to four words, sleep, then collect the replies in one pass. Chip select is left to general-purpose pins outside this block. A software-only read is done by writing zeros to the data port.

Top module: `spim_top`

## Requirements
- R1: After reset the master control register reads 0x0040 (configuration mode), control 0 reads 0x0000, control 1 reads 0x0108 (divider 1, 8-bit words), status reads 0x0004, the interrupt is low and the serial clock is low.
- R2: Master control bits [7:6] hold the mode: 01 is configuration and 10 is active. A word leaves the transmit FIFO only in active mode and only when that FIFO is not empty; words written in any other mode stay queued.
- R3: Each FIFO holds 4 words. A data-port write (offset 0x18) to a full transmit FIFO is dropped, and a data-port read of an empty receive FIFO returns 0; neither moves any FIFO count.
- R4: Writing master control (offset 0x00) with bit 0 set empties both FIFOs.
- R5: Writes to control 0 (offset 0x04) and control 1 (offset 0x08) take effect only in configuration mode; in active mode they leave both registers unchanged.
- R6: Control 1 holds the divider n in bits [15:8] and the word length in bits [7:0]. A written divider of 0 is stored as 1. A length of 16 selects 16-bit words and any other value selects 8-bit words; the field reads back 16 or 8. One serial clock period lasts n+1 clock cycles.
- R7: Control 0 bit 0 sets the serial clock idle level and bit 1 the phase: with phase 0 the data is sampled on the leading clock edge, with phase 1 on the trailing edge. Data leaves most-significant bit first.
- R8: Every word sent captures exactly one received word. In 8-bit mode only the low 8 bits of a queued word are sent, and the received byte is returned right-aligned with bits [15:8] zero.
- R9: Status (offset 0x14) bits [10:8] give the receive fill, bits [13:11] the transmit fill, bit 14 is set when the receive fill is at least control 0 bits [13:12] plus one, and bit 2 is set when the shifter is idle and the transmit FIFO is empty; all other bits read 0.
- R10: The interrupt is the status bit 14 condition ANDed with control 0 bit 9; clearing that bit drops the interrupt on the next cycle.
- R11: A word starts only when the receive FIFO has room for its reply, so a full receive FIFO holds back further transfers until software reads a word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid during the access cycle |
| irq | output | 1 | Receive-threshold interrupt, level |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
Register writes take effect at the clock edge that ends the access, so the bench reads back in a following access; read data is combinational and is sampled one time unit after the access is driven, before the edge that pops the receive FIFO. Serial results complete (n+1)·bits cycles after a word is loaded, so rather than counting to a fixed cycle the bench polls the idle status bit and only then checks fills, interrupt and received words. Captured serial bits and the clock period are taken on the serial clock edges themselves by a bench monitor that knows the programmed polarity and phase.

// File: rtl/spim_pkg.sv
package spim_pkg;

  typedef enum logic [1:0] {
    MODE_OFF = 2'b00,
    MODE_CFG = 2'b01,
    MODE_ACT = 2'b10,
    MODE_RSV = 2'b11
  } mode_e;

  localparam logic [4:0] OFS_MCTL = 5'h00;
  localparam logic [4:0] OFS_CTL0 = 5'h04;
  localparam logic [4:0] OFS_CTL1 = 5'h08;
  localparam logic [4:0] OFS_STAT = 5'h14;
  localparam logic [4:0] OFS_DATA = 5'h18;

  typedef struct packed {
    logic [1:0] tx_thr;
    logic [1:0] rx_thr;
    logic       rx_ie;
    logic       tx_ie;
    logic       pha;
    logic       pol;
  } ctl0_t;

endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clr,
  input  logic                         push,
  input  logic [W-1:0]                 din,
  input  logic                         pop,
  output logic [W-1:0]                 dout,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         full,
  output logic                         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push && !full && !clr;
  assign do_pop  = pop && !empty && !clr;
  assign count   = cnt_q;
  assign dout    = mem[rp_q];

  function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (clr) begin
      wp_d  = '0;
      rp_d  = '0;
      cnt_d = '0;
    end else begin
      if (do_push) wp_d = wrap_inc(wp_q);
      if (do_pop)  rp_d = wrap_inc(rp_q);
      case ({do_push, do_pop})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= din;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH)); // R3
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop && !clr) |=> (cnt_q == CW'(DEPTH))); // R3

endmodule

// File: rtl/spim_shifter.sv
module spim_shifter #(
  parameter int DIVW = 8,
  parameter int W    = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            pol,
  input  logic            pha,
  input  logic            wide_cfg,
  input  logic [DIVW-1:0] div,
  input  logic            tx_valid,
  input  logic [W-1:0]    tx_word,
  output logic            tx_pop,
  input  logic            rx_room,
  output logic            rx_push,
  output logic [W-1:0]    rx_word,
  output logic            busy,
  output logic            sclk,
  output logic            mosi,
  input  logic            miso
);
  localparam int HW  = W / 2;
  localparam int BCW = $clog2(W);

  logic            busy_q, busy_d, wide_q, wide_d;
  logic [DIVW-1:0] cnt_q, cnt_d, half;
  logic [BCW-1:0]  bit_q, bit_d;
  logic [W-1:0]    sh_q, sh_d, sh_next;
  logic            smp_q, smp_d, sclk_q, sclk_d, mosi_q, mosi_d;
  logic            start, lead, trail, last_bit;

  assign half     = div >> 1;
  assign start    = run && tx_valid && rx_room && !busy_q;
  assign lead     = busy_q && (cnt_q == half);
  assign trail    = busy_q && (cnt_q == div);
  assign last_bit = (bit_q == (wide_q ? BCW'(W-1) : BCW'(HW-1)));
  assign sh_next  = {sh_q[W-2:0], pha ? miso : smp_q};

  always_comb begin
    busy_d = busy_q;
    wide_d = wide_q;
    cnt_d  = cnt_q;
    bit_d  = bit_q;
    sh_d   = sh_q;
    smp_d  = smp_q;
    sclk_d = sclk_q;
    mosi_d = mosi_q;
    if (start) begin
      busy_d = 1'b1;
      wide_d = wide_cfg;
      cnt_d  = '0;
      bit_d  = '0;
      sh_d   = wide_cfg ? tx_word : {tx_word[HW-1:0], {HW{1'b0}}};
      sclk_d = pol;
      if (!pha) mosi_d = wide_cfg ? tx_word[W-1] : tx_word[HW-1];
    end else if (busy_q) begin
      cnt_d = trail ? '0 : cnt_q + 1'b1;
      if (lead) begin
        sclk_d = ~pol;
        if (!pha) smp_d  = miso;
        else      mosi_d = sh_q[W-1];
      end
      if (trail) begin
        sclk_d = pol;
        sh_d   = sh_next;
        bit_d  = bit_q + 1'b1;
        if (!pha) mosi_d = sh_q[W-2];
        if (last_bit) busy_d = 1'b0;
      end
    end else begin
      sclk_d = pol;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      wide_q <= 1'b0;
      cnt_q  <= '0;
      bit_q  <= '0;
      sh_q   <= '0;
      smp_q  <= 1'b0;
      sclk_q <= 1'b0;
      mosi_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      wide_q <= wide_d;
      cnt_q  <= cnt_d;
      bit_q  <= bit_d;
      sh_q   <= sh_d;
      smp_q  <= smp_d;
      sclk_q <= sclk_d;
      mosi_q <= mosi_d;
    end
  end

  assign tx_pop  = start;
  assign rx_push = trail && last_bit;
  assign rx_word = wide_q ? sh_next : {{HW{1'b0}}, sh_next[HW-1:0]};
  assign busy    = busy_q;
  assign sclk    = sclk_q;
  assign mosi    = mosi_q;

  AST_ONE_REPLY: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |=> !busy_q); // R8
  AST_LOAD_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |=> (busy_q && bit_q == '0)); // R2

endmodule

// File: rtl/spim_top.sv
module spim_top #(
  parameter int DEPTH = 4,
  parameter int DIVW  = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_req,
  input  logic        bus_we,
  input  logic [4:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        irq,
  output logic        sclk,
  output logic        mosi,
  input  logic        miso
);
  import spim_pkg::*;

  localparam int W  = 16;
  localparam int CW = $clog2(DEPTH+1);

  logic [1:0]      rst_sync;
  logic            rst_ni;
  mode_e           mode_q, mode_d;
  ctl0_t           ctl0_q, ctl0_d;
  logic [DIVW-1:0] div_q, div_d;
  logic            wide_q, wide_d;
  logic            wr, rd, cfg_ok, bclr, data_wr, data_rd;
  logic [W-1:0]    tx_dout, rx_dout, rx_word;
  logic [CW-1:0]   tx_cnt, rx_cnt;
  logic            tx_full, tx_empty, rx_full, rx_empty;
  logic            tx_pop, rx_push, busy, rx_hit, idle;
  logic [15:0]     stat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ni = rst_sync[1];

  assign wr      = bus_req && bus_we;
  assign rd      = bus_req && !bus_we;
  assign cfg_ok  = (mode_q == MODE_CFG);
  assign bclr    = wr && (bus_addr == OFS_MCTL) && bus_wdata[0];
  assign data_wr = wr && (bus_addr == OFS_DATA);
  assign data_rd = rd && (bus_addr == OFS_DATA);

  always_comb begin
    mode_d = mode_q;
    ctl0_d = ctl0_q;
    div_d  = div_q;
    wide_d = wide_q;
    if (wr && bus_addr == OFS_MCTL) mode_d = mode_e'(bus_wdata[7:6]);
    if (wr && cfg_ok && bus_addr == OFS_CTL0) begin
      ctl0_d.tx_thr = bus_wdata[15:14];
      ctl0_d.rx_thr = bus_wdata[13:12];
      ctl0_d.rx_ie  = bus_wdata[9];
      ctl0_d.tx_ie  = bus_wdata[8];
      ctl0_d.pha    = bus_wdata[1];
      ctl0_d.pol    = bus_wdata[0];
    end
    if (wr && cfg_ok && bus_addr == OFS_CTL1) begin
      div_d  = (bus_wdata[15:8] == '0) ? DIVW'(1) : DIVW'(bus_wdata[15:8]);
      wide_d = (bus_wdata[7:0] == 8'd16);
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_CFG;
      ctl0_q <= '0;
      div_q  <= DIVW'(1);
      wide_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
      ctl0_q <= ctl0_d;
      div_q  <= div_d;
      wide_q <= wide_d;
    end
  end

  spim_fifo #(.W(W), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_ni), .clr(bclr),
    .push(data_wr), .din(bus_wdata), .pop(tx_pop), .dout(tx_dout),
    .count(tx_cnt), .full(tx_full), .empty(tx_empty)
  );

  spim_fifo #(.W(W), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_ni), .clr(bclr),
    .push(rx_push), .din(rx_word), .pop(data_rd), .dout(rx_dout),
    .count(rx_cnt), .full(rx_full), .empty(rx_empty)
  );

  spim_shifter #(.DIVW(DIVW), .W(W)) u_shift (
    .clk(clk), .rst_n(rst_ni), .run(mode_q == MODE_ACT),
    .pol(ctl0_q.pol), .pha(ctl0_q.pha), .wide_cfg(wide_q), .div(div_q),
    .tx_valid(!tx_empty), .tx_word(tx_dout), .tx_pop(tx_pop),
    .rx_room(!rx_full), .rx_push(rx_push), .rx_word(rx_word),
    .busy(busy), .sclk(sclk), .mosi(mosi), .miso(miso)
  );

  assign rx_hit = (rx_cnt > CW'(ctl0_q.rx_thr));
  assign idle   = !busy && tx_empty;
  assign irq    = rx_hit && ctl0_q.rx_ie;

  always_comb begin
    stat        = '0;
    stat[14]    = rx_hit;
    stat[13:11] = 3'(tx_cnt);
    stat[10:8]  = 3'(rx_cnt);
    stat[2]     = idle;
  end

  always_comb begin
    case (bus_addr)
      OFS_MCTL: bus_rdata = {8'h00, mode_q, 6'h00};
      OFS_CTL0: bus_rdata = {ctl0_q.tx_thr, ctl0_q.rx_thr, 2'b00, ctl0_q.rx_ie,
                             ctl0_q.tx_ie, 6'h00, ctl0_q.pha, ctl0_q.pol};
      OFS_CTL1: bus_rdata = {8'(div_q), wide_q ? 8'd16 : 8'd8};
      OFS_STAT: bus_rdata = stat;
      OFS_DATA: bus_rdata = rx_empty ? 16'h0000 : rx_dout;
      default:  bus_rdata = 16'h0000;
    endcase
  end

  AST_CTL_LOCKED: assert property (@(posedge clk) disable iff (!rst_ni)
    (mode_q == MODE_ACT) |=> ($stable(ctl0_q) && $stable(div_q) && $stable(wide_q))); // R5
  AST_TX_HOLD_CFG: assert property (@(posedge clk) disable iff (!rst_ni)
    (mode_q != MODE_ACT && !busy && !data_wr && !bclr) |=> $stable(tx_cnt)); // R2
  AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_ni)
    bclr |=> (tx_cnt == '0)); // R4
  AST_IRQ_FALLS: assert property (@(posedge clk) disable iff (!rst_ni)
    $fell(ctl0_q.rx_ie) |-> !irq); // R10
  AST_DIV_NONZERO: assert property (@(posedge clk) disable iff (!rst_ni)
    div_q != '0); // R6

endmodule

// File: tb/spim_top_tb_top.sv
`timescale 1ns/1ps
module spim_top_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_req = 1'b0, bus_we = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq, sclk, mosi, miso;
  logic        inv = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign miso = mosi ^ inv;

  spim_top dut_i (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .sclk(sclk), .mosi(mosi), .miso(miso)
  );

  int vectors = 0;
  int fails   = 0;
  bit done    = 0;

  // serial monitor
  logic cfg_pol = 1'b0, cfg_pha = 1'b0;
  logic cbits [0:63];
  int   capn = 0;
  int   tick = 0;
  int   last_lead = -1;
  int   per = 0;

  always @(posedge clk) tick++;

  always @(sclk) begin
    logic lead;
    lead = (sclk !== cfg_pol);
    if ((cfg_pha ? !lead : lead) && capn < 64) begin
      cbits[capn] = mosi;
      capn++;
    end
    if (lead) begin
      if (last_lead >= 0) per = tick - last_lead;
      last_lead = tick;
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_rd(input logic [4:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_req = 1'b0;
  endtask

  function automatic logic [15:0] exp_stat(input int rxc, input int txc,
                                           input bit hit, input bit idl);
    return (16'(hit) << 14) | (16'(txc) << 11) | (16'(rxc) << 8) | (16'(idl) << 2);
  endfunction

  function automatic logic [15:0] exp_rx(input logic [15:0] w, input bit wide,
                                         input bit iv);
    logic [15:0] r;
    r = iv ? ~w : w;
    return wide ? r : {8'h00, r[7:0]};
  endfunction

  task automatic wait_idle();
    logic [15:0] s;
    for (int i = 0; i < 4000; i++) begin
      bus_rd(5'h14, s);
      if (s[2]) break;
    end
  endtask

  task automatic setup(input bit pol, input bit pha, input bit wide,
                       input int dv, input int thr, input bit rie);
    bus_wr(5'h00, 16'h0040);
    bus_wr(5'h04, 16'((thr << 12) | (int'(rie) << 9) | (int'(pha) << 1) | int'(pol)));
    bus_wr(5'h08, 16'((dv << 8) | (wide ? 16 : 8)));
    cfg_pol = pol;
    cfg_pha = pha;
    bus_wr(5'h00, 16'h0080);
    capn = 0;
    last_lead = -1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] r;
    logic [15:0] txw [4];
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    bus_rd(5'h00, r); chk("R1", "mctl", r, 16'h0040);
    bus_rd(5'h04, r); chk("R1", "ctl0", r, 16'h0000);
    bus_rd(5'h08, r); chk("R1", "ctl1", r, 16'h0108);
    bus_rd(5'h14, r); chk("R1", "status", r, 16'h0004);
    chk("R1", "irq", irq, 0);
    chk("R1", "sclk", sclk, 0);

    // R2/R3: words queue in config mode, fifth is dropped
    for (int i = 0; i < 5; i++) bus_wr(5'h18, 16'h1111 * (i + 1));
    repeat (20) @(negedge clk);
    bus_rd(5'h14, r); chk("R3", "tx full drop", r, exp_stat(0, 4, 0, 0));
    chk("R2", "no shifting in config", sclk, 0);

    // R4 buffer clear
    bus_wr(5'h00, 16'h0041);
    bus_rd(5'h14, r); chk("R4", "clear", r, 16'h0004);

    // R3 empty read
    bus_rd(5'h18, r); chk("R3", "empty read", r, 16'h0000);
    bus_rd(5'h14, r); chk("R3", "empty read counts", r, 16'h0004);

    // R6 divider clamp and length decode
    bus_wr(5'h08, 16'h0010);
    bus_rd(5'h08, r); chk("R6", "div clamp", r, 16'h0110);
    bus_wr(5'h08, 16'h0305);
    bus_rd(5'h08, r); chk("R6", "length other", r, 16'h0308);

    // R5 lock in active mode
    bus_wr(5'h04, 16'h0003);
    bus_wr(5'h00, 16'h0080);
    bus_wr(5'h04, 16'hFFFC);
    bus_wr(5'h08, 16'h0710);
    bus_rd(5'h04, r); chk("R5", "ctl0 locked", r, 16'h0003);
    bus_rd(5'h08, r); chk("R5", "ctl1 locked", r, 16'h0308);

    // R11 receive full stalls, R10 interrupt level and clear
    inv = 1'b0;
    setup(0, 0, 0, 1, 3, 1);
    for (int i = 0; i < 4; i++) bus_wr(5'h18, 16'(8'h30 + i));
    wait_idle();
    for (int i = 0; i < 4; i++) bus_wr(5'h18, 16'(8'h40 + i));
    repeat (200) @(negedge clk);
    bus_rd(5'h14, r); chk("R11", "stall", r, exp_stat(4, 4, 1, 0));
    chk("R10", "irq at threshold", irq, 1);
    bus_rd(5'h18, r); chk("R11", "first reply", r, 16'h0030);
    repeat (100) @(negedge clk);
    bus_rd(5'h14, r); chk("R11", "one more word", r, exp_stat(4, 3, 1, 0));
    bus_wr(5'h00, 16'h0040);
    bus_wr(5'h04, 16'h3000);
    chk("R10", "irq after enable cleared", irq, 0);
    bus_wr(5'h00, 16'h0041);
    bus_rd(5'h14, r); chk("R4", "clear both", r, 16'h0004);

    // random vectors
    for (int v = 0; v < 40; v++) begin
      bit pol, pha, wide, rie, hit;
      int dv, thr, k, nb, bad;
      pol  = 1'($urandom % 2);
      pha  = 1'($urandom % 2);
      wide = 1'($urandom % 2);
      rie  = 1'($urandom % 2);
      dv   = 1 + int'($urandom % 6);
      thr  = int'($urandom % 4);
      k    = 1 + int'($urandom % 4);
      if (v == 0) begin dv = 1; k = 4; wide = 1; end
      inv  = 1'($urandom % 2);
      nb   = wide ? 16 : 8;
      hit  = (k > thr);
      setup(pol, pha, wide, dv, thr, rie);
      for (int i = 0; i < k; i++) begin
        txw[i] = 16'($urandom);
        bus_wr(5'h18, txw[i]);
      end
      wait_idle();
      repeat (2) @(negedge clk);
      bus_rd(5'h14, r); chk("R9", "status after burst", r, exp_stat(k, 0, hit, 1));
      chk("R10", "irq", irq, rie && hit);
      chk("R7", "idle level", sclk, pol);
      chk("R7", "bit count", capn, k * nb);
      bad = 0;
      for (int i = 0; i < k; i++)
        for (int b = 0; b < nb; b++)
          if (i * nb + b < 64 && cbits[i * nb + b] !== txw[i][nb - 1 - b]) bad++;
      chk("R7", "msb-first bits", bad, 0);
      chk("R6", "sclk period", per, dv + 1);
      for (int i = 0; i < k; i++) begin
        bus_rd(5'h18, r);
        chk("R8", "reply word", r, exp_rx(txw[i], wide, inv));
      end
      bus_rd(5'h14, r); chk("R9", "status drained", r, exp_stat(0, 0, 0, 1));
    end

    finish_run();
  end

endmodule